// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

An eight-stage register that turns a parallel byte into a serial bit stream. A low level on the load control copies the parallel word into the stages. While the load control is high, each rising edge of the gated shift clock moves every stage one step toward the last stage and takes the serial input into the first stage. The last stage is driven out in true and inverted form. The serial input lets several of these registers be chained.

The block runs in a fast system clock domain. The external shift clock, clock-inhibit and load control are treated as ordinary asynchronous inputs. Each passes through a two-flop synchroniser. The effective shift clock is the OR of the synchronised shift clock and clock-inhibit. A shift fires when that OR changes from 0 to 1. The parallel data and the serial input must be stable around the moment they are taken.

Top module: `piso_shift_reg`

## Requirements
- R1: On each shift, `ser_i` enters the first stage (the stage loaded from `par_i[0]`), and every other stage takes the value of the stage below it. `q_o` shows the last stage (the stage loaded from `par_i[7]`), so a loaded byte leaves on `q_o` from bit 7 down to bit 0.
- R2: While the synchronised `load_ni` is low, the stages follow `par_i`. Shift clock edges, clock-inhibit edges and `ser_i` are ignored in that time, including an edge that lands in the same system cycle as the load.
- R3: A 0-to-1 change of the synchronised `sclk_i`, while `sinh_i` is low and `load_ni` is high, causes exactly one shift.
- R4: A 0-to-1 change of `sinh_i` while `sclk_i` is low causes exactly one shift, so the two pins act interchangeably.
- R5: A rise of `sinh_i` while `sclk_i` is high causes no shift. A rise of `sclk_i` while `sinh_i` is high causes no shift. Falling edges of either pin never shift.
- R6: While `load_ni` is high, changes on `par_i` leave the stages unchanged.
- R7: `q_no` is always the inverse of `q_o`.
- R8: While `rst_ni` is low, all stages clear to 0, so `q_o` reads 0 and `q_no` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| par_i | input | 8 | Parallel data; bit 0 feeds the first stage, bit 7 the last |
| load_ni | input | 1 | Active-low level-sensitive load |
| ser_i | input | 1 | Serial input into the first stage |
| sclk_i | input | 1 | External shift clock |
| sinh_i | input | 1 | Clock-inhibit, ORed with the shift clock |
| q_o | output | 1 | Last stage, true |
| q_no | output | 1 | Last stage, inverted |

## Verification
The bench raises the inhibit while the shift clock is high, and raises the shift clock while the inhibit is high. A design that shifts on each pin's edge separately, instead of on their OR, would drop a bit in these cases. The bench pulses the shift clock during a load. A design that lets the edge win would shift the freshly loaded word. It changes `par_i` while the load control is high, which exposes a load that is edge-less or leaks through. Each blocked case is followed by a full readout, so a hidden shift shows up as a misaligned bit order.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef struct packed {
    logic load_n;
    logic sclk;
    logic sinh;
  } piso_ctl_t;

  localparam int unsigned CTL_W = $bits(piso_ctl_t);
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe[g] <= RST_VAL;
      else if (g == 0) pipe[g] <= d_i;
      else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/piso_edge_det.sv
module piso_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sinh_i,
  output logic rise_o
);
  logic gclk, gclk_q;

  // interchangeable pins: the effective clock is their OR
  assign gclk = sclk_i | sinh_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gclk_q <= 1'b0;
    else gclk_q <= gclk;
  end

  assign rise_o = gclk & ~gclk_q;
endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] stages_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stages_o <= '0;
    else if (!load_ni) stages_o <= par_i; // load overrides any edge
    else if (shift_i) stages_o <= {stages_o[WIDTH-2:0], ser_i};
  end
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] par_i,
  input  logic             load_ni,
  input  logic             ser_i,
  input  logic             sclk_i,
  input  logic             sinh_i,
  output logic             q_o,
  output logic             q_no
);
  localparam piso_ctl_t CTL_RST = '{load_n: 1'b1, sclk: 1'b0, sinh: 1'b0};

  piso_ctl_t ctl_raw, ctl_s;
  logic load_n_s, sclk_s, sinh_s, shift;
  logic [WIDTH-1:0] stages;

  assign ctl_raw = '{load_n: load_ni, sclk: sclk_i, sinh: sinh_i};

  piso_sync #(
    .W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ctl_raw), .q_o(ctl_s)
  );

  assign load_n_s = ctl_s.load_n;
  assign sclk_s   = ctl_s.sclk;
  assign sinh_s   = ctl_s.sinh;

  piso_edge_det u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sclk_i(sclk_s), .sinh_i(sinh_s), .rise_o(shift)
  );

  piso_stages #(.WIDTH(WIDTH)) u_stages (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_ni(load_n_s), .shift_i(shift),
    .par_i(par_i), .ser_i(ser_i), .stages_o(stages)
  );

  assign q_o  = stages[WIDTH-1];
  assign q_no = ~stages[WIDTH-1];
endmodule

// File: rtl/piso_shift_reg_chk.sv
module piso_shift_reg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_n_s,
  input logic             sclk_s,
  input logic             shift,
  input logic [WIDTH-1:0] stages,
  input logic [WIDTH-1:0] par_i,
  input logic             ser_i,
  input logic             q_o,
  input logic             q_no
);
  p_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift && load_n_s) |=> stages == {$past(stages[WIDTH-2:0]), $past(ser_i)});

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_n_s |=> stages == $past(par_i));

  p_no_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_n_s && !shift) |=> $stable(stages));

  p_clk_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_n_s && sclk_s && $past(sclk_s)) |=> $stable(stages));

  p_comp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_no == !q_o);

  p_out_last_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o == stages[WIDTH-1]);
endmodule

bind piso_shift_reg piso_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_n_s(load_n_s), .sclk_s(sclk_s),
  .shift(shift), .stages(stages), .par_i(par_i), .ser_i(ser_i),
  .q_o(q_o), .q_no(q_no)
);

// File: tb/piso_shift_reg_tb.sv
module piso_shift_reg_tb;
  localparam int W = 8;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] par_i = '0;
  logic load_ni = 1'b1, ser_i = 1'b0, sclk_i = 1'b0, sinh_i = 1'b0;
  logic q_o, q_no;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  logic [W-1:0] exp_q;

  always #4 clk = ~clk;

  piso_shift_reg #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .par_i(par_i), .load_ni(load_ni),
    .ser_i(ser_i), .sclk_i(sclk_i), .sinh_i(sinh_i), .q_o(q_o), .q_no(q_no)
  );

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: q_o/q_no act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic check_out(string req);
    check(req, q_o, exp_q[W-1]);
    check("R7", q_no, ~exp_q[W-1]);
  endtask

  function automatic logic [W-1:0] shift_model(logic [W-1:0] v, logic s);
    return {v[W-2:0], s};
  endfunction

  task automatic do_load(logic [W-1:0] d);
    par_i = d; load_ni = 1'b0; wait_n(SETTLE);
    load_ni = 1'b1; wait_n(SETTLE);
    exp_q = d;
  endtask

  // mode 0: sclk edge; mode 1: sinh edge with sclk low
  task automatic shift_one(logic s, bit mode);
    ser_i = s;
    if (!mode) begin sclk_i = 1'b1; wait_n(SETTLE); sclk_i = 1'b0; end
    else begin sinh_i = 1'b1; wait_n(SETTLE); sinh_i = 1'b0; end
    wait_n(SETTLE);
    exp_q = shift_model(exp_q, s);
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < W; i++) begin
      check_out(req);
      shift_one(1'b0, 1'b0);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2468);
    exp_q = '0;
    wait_n(3);
    check_out("R8");
    rst_ni = 1'b1;
    wait_n(SETTLE);
    check_out("R8");

    // R2 load then R1/R3/R4 ordered readout with serial fill
    do_load(8'b1011_0010);
    check_out("R2");
    for (int i = 0; i < W; i++) begin
      shift_one(1'(i & 1), 1'(i >> 1));
      check_out((i >> 1) != 0 ? "R4" : "R3");
    end
    check_out("R1");

    // R5: inhibit rises while sclk high, sclk rises while inhibit high
    do_load(8'hA5);
    sclk_i = 1'b1; wait_n(SETTLE);
    exp_q = shift_model(exp_q, ser_i);
    sinh_i = 1'b1; wait_n(SETTLE);
    sclk_i = 1'b0; wait_n(SETTLE);
    sclk_i = 1'b1; wait_n(SETTLE);
    sinh_i = 1'b0; wait_n(SETTLE);
    sclk_i = 1'b0; wait_n(SETTLE);
    check_out("R5");
    read_all("R5");

    // R6: parallel data changes with load high
    do_load(8'h3C);
    par_i = 8'hC3; wait_n(SETTLE);
    par_i = 8'hFF; wait_n(SETTLE);
    read_all("R6");

    // R2: edges and serial input during load are ignored
    par_i = 8'h96; ser_i = 1'b1; load_ni = 1'b0; wait_n(SETTLE);
    sclk_i = 1'b1; wait_n(SETTLE); sclk_i = 1'b0;
    sinh_i = 1'b1; wait_n(SETTLE); sinh_i = 1'b0; wait_n(SETTLE);
    load_ni = 1'b1; wait_n(SETTLE);
    exp_q = 8'h96;
    read_all("R2");

    // random mix
    for (int it = 0; it < 20; it++) begin
      do_load(W'($urandom));
      check_out("R2");
      for (int k = 0; k < 6; k++) begin
        shift_one(1'($urandom), 1'($urandom));
        check_out("R1");
      end
    end

    // R8: reset mid-stream
    do_load(8'hFF);
    rst_ni = 1'b0; wait_n(2);
    exp_q = '0;
    check_out("R8");
    rst_ni = 1'b1; wait_n(SETTLE);
    check_out("R8");

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: cycles act=%0d exp<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule